// File: doc/BRIEF.md
# Inter-Port Semaphore Flag Unit

This block keeps eight hardware token flags that two independent ports share. Software on either side uses them to claim and return a shared resource without racing the other side. Each port has its own select, chip enable, read/write strobe, output enable, a 3-bit flag address, a 9-bit write bus and a 9-bit read bus with an enable.

A port makes a request by writing 0 in data bit 0. It returns the flag, or withdraws a request that is still waiting, by writing 1 in that bit. A request is granted only while the other port does not hold the flag. A request that is refused stays pending and is granted on its own once the flag is returned. When both ports claim a free flag together, the left port wins.

Reads are combinational. A read places the port's view of the flag on all nine data bits: zero means this port holds the flag, and all ones means it does not. Both ports are sampled on one clock. A write is detected when the sampled read/write strobe goes from low to high.

Top module: `sem_flag_unit`

## Requirements
- R1: After reset no flag is held and no request is pending, so a read of any flag from either port returns 9'h1FF.
- R2: A write is taken at the clock edge where the strobe is sampled high after being sampled low, with select low and chip enable high. If data bit 0 is 0, the write requests the flag addressed by address bits [2:0]. A free flag is held from the following edge.
- R3: While select is low, chip enable is high, read/write is high and output enable is low, the read enable is 1. The read bus then carries 9'h000 if this port holds the addressed flag and 9'h1FF otherwise. In every other case the read enable is 0.
- R4: A request for a flag that the other port holds stays pending. It is granted one edge after the holder releases the flag.
- R5: The two ports never hold the same flag at the same time.
- R6: If both ports request a free flag at the same edge, the left port is granted it and the right request stays pending.
- R7: A write with data bit 0 equal to 1 releases the addressed flag and cancels any pending request from that port.
- R8: An access with chip enable low and select low is ignored. It changes no flag, and its read enable is 0.
- R9: The eight flags are independent of each other. Holding one flag does not affect a request for a different flag.
- R10: Only data bit 0 of a write is used: 9'h1FE requests the flag, and 9'h0FF releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l_sem_n | input | 1 | Left semaphore select, active low |
| l_ce_n | input | 1 | Left memory chip enable, active low (must be high for a flag access) |
| l_rw | input | 1 | Left read/write strobe: high for read, a low-to-high transition writes |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | 3 | Left flag address |
| l_din | input | 9 | Left write data (bit 0 used) |
| l_dout | output | 9 | Left read data |
| l_doe | output | 1 | Left read data valid/drive enable |
| r_sem_n | input | 1 | Right semaphore select, active low |
| r_ce_n | input | 1 | Right memory chip enable, active low |
| r_rw | input | 1 | Right read/write strobe |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | 3 | Right flag address |
| r_din | input | 9 | Right write data (bit 0 used) |
| r_dout | output | 9 | Right read data |
| r_doe | output | 1 | Right read data valid/drive enable |

## Verification
Two functions can meet in one cycle. The first case is two claims on the same free flag that land on the same edge, so the tie rule must choose a single owner. The second case is a release from one port while the other port's request is waiting. The bench creates the tie by strobing both ports on the same edge. It then reads each side and expects zeros on the left and ones on the right. Next it releases the left hold and expects the right port to take the flag. It also cancels a waiting request before the holder releases, and then checks that the flag comes back free rather than passing to the withdrawn claimant.

// File: rtl/sem_flag_unit.sv
module sem_flag_unit #(
  parameter int NFLAG = 8,
  parameter int DW    = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     l_sem_n,
  input  logic                     l_ce_n,
  input  logic                     l_rw,
  input  logic                     l_oe_n,
  input  logic [$clog2(NFLAG)-1:0] l_addr,
  input  logic [DW-1:0]            l_din,
  output logic [DW-1:0]            l_dout,
  output logic                     l_doe,
  input  logic                     r_sem_n,
  input  logic                     r_ce_n,
  input  logic                     r_rw,
  input  logic                     r_oe_n,
  input  logic [$clog2(NFLAG)-1:0] r_addr,
  input  logic [DW-1:0]            r_din,
  output logic [DW-1:0]            r_dout,
  output logic                     r_doe
);
  localparam int AW = $clog2(NFLAG);

  logic [NFLAG-1:0] hold_l, hold_r, req_l, req_r;
  logic [NFLAG-1:0] hold_l_n, hold_r_n, req_l_n, req_r_n;
  logic [NFLAG-1:0] l_hit, r_hit, free, gnt_l, gnt_r;
  logic             l_rw_q, r_rw_q;
  logic             l_sel, r_sel, l_wr, r_wr;
  logic             l_claim, l_rel, r_claim, r_rel;
  logic             unused_hi;

  assign unused_hi = ^{l_din[DW-1:1], r_din[DW-1:1]};

  // a flag access needs select low with the memory enable released
  assign l_sel = !l_sem_n && l_ce_n;
  assign r_sel = !r_sem_n && r_ce_n;

  assign l_wr = l_sel && l_rw && !l_rw_q;
  assign r_wr = r_sel && r_rw && !r_rw_q;

  assign l_claim = l_wr && !l_din[0];
  assign l_rel   = l_wr &&  l_din[0];
  assign r_claim = r_wr && !r_din[0];
  assign r_rel   = r_wr &&  r_din[0];

  assign l_hit = NFLAG'(1) << l_addr;
  assign r_hit = NFLAG'(1) << r_addr;

  assign free  = ~hold_l & ~hold_r;
  assign gnt_l = free & req_l;
  assign gnt_r = free & req_r & ~req_l;

  always_comb begin
    hold_l_n = hold_l | gnt_l;
    hold_r_n = hold_r | gnt_r;
    req_l_n  = req_l & ~gnt_l;
    req_r_n  = req_r & ~gnt_r;
    if (l_rel) begin
      hold_l_n = hold_l_n & ~l_hit;
      req_l_n  = req_l_n  & ~l_hit;
    end
    if (l_claim) req_l_n = req_l_n | (l_hit & ~hold_l_n);
    if (r_rel) begin
      hold_r_n = hold_r_n & ~r_hit;
      req_r_n  = req_r_n  & ~r_hit;
    end
    if (r_claim) req_r_n = req_r_n | (r_hit & ~hold_r_n);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_l <= '0;
      hold_r <= '0;
      req_l  <= '0;
      req_r  <= '0;
      l_rw_q <= 1'b1;
      r_rw_q <= 1'b1;
    end else begin
      hold_l <= hold_l_n;
      hold_r <= hold_r_n;
      req_l  <= req_l_n;
      req_r  <= req_r_n;
      l_rw_q <= l_rw;
      r_rw_q <= r_rw;
    end
  end

  assign l_doe  = l_sel && l_rw && !l_oe_n;
  assign r_doe  = r_sel && r_rw && !r_oe_n;
  assign l_dout = {DW{~hold_l[l_addr]}};
  assign r_dout = {DW{~hold_r[r_addr]}};

  assert_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_l & hold_r) == '0);

  assert_ignore_l_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !l_ce_n |-> !l_doe);
  assert_ignore_r_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !r_ce_n |-> !r_doe);

  assert_read_rep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    l_doe |-> (l_dout == {DW{l_dout[0]}}));

  for (genvar i = 0; i < NFLAG; i++) begin : g_chk
    assert_tie_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_l[i] && req_r[i] && !hold_l[i] && !hold_r[i] && !(l_rel && l_hit[i]))
      |=> hold_l[i]);
    assert_grant_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_r[i]) |-> $past(req_r[i]));
    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (l_rel && l_hit[i]) |=> (!hold_l[i] && !req_l[i]));
  end
endmodule

// File: tb/sem_flag_unit_tb.sv
module sem_flag_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_sem_n = 1, l_ce_n = 1, l_rw = 1, l_oe_n = 1;
  logic r_sem_n = 1, r_ce_n = 1, r_rw = 1, r_oe_n = 1;
  logic [2:0] l_addr = '0, r_addr = '0;
  logic [8:0] l_din = '0, r_din = '0;
  logic [8:0] l_dout, r_dout;
  logic l_doe, r_doe;

  always #2 clk = ~clk;

  sem_flag_unit dut_i (.*);

  typedef struct {
    string      tag;
    int         port;
    logic [8:0] val;
    logic       oe;
  } exp_t;

  exp_t q[$];
  event sample_ev;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  initial begin
    forever begin
      @(sample_ev);
      while (q.size() > 0) begin
        exp_t e;
        logic [8:0] d;
        logic o;
        e = q.pop_front();
        d = (e.port == 0) ? l_dout : r_dout;
        o = (e.port == 0) ? l_doe  : r_doe;
        n_tests++;
        if (o !== e.oe || (e.oe && d !== e.val)) begin
          n_fail++;
          $display("FAIL %s port=%0d got dout=%h oe=%b expected dout=%h oe=%b",
                   e.tag, e.port, d, o, e.val, e.oe);
        end
      end
    end
  end

  task automatic drive(input int p, input logic sn, input logic ce, input logic rw,
                       input logic oe, input logic [2:0] a, input logic [8:0] d);
    if (p == 0 || p == 2) begin
      l_sem_n = sn; l_ce_n = ce; l_rw = rw; l_oe_n = oe; l_addr = a; l_din = d;
    end
    if (p == 1 || p == 2) begin
      r_sem_n = sn; r_ce_n = ce; r_rw = rw; r_oe_n = oe; r_addr = a; r_din = d;
    end
  endtask

  // p: 0 left, 1 right, 2 both on the same edge
  task automatic sem_write(input int p, input logic [2:0] a, input logic [8:0] d,
                           input logic ce = 1'b1);
    @(negedge clk); drive(p, 0, ce, 0, 1, a, d);
    @(negedge clk); drive(p, 0, ce, 1, 1, a, d);
    @(negedge clk); drive(p, 1, 1, 1, 1, a, d);
    @(negedge clk);
  endtask

  task automatic sem_read(input string tag, input int p, input logic [2:0] a,
                          input logic [8:0] v, input logic oe = 1'b1,
                          input logic ce = 1'b1, input logic oen = 1'b0);
    exp_t e;
    @(negedge clk);
    drive(p, 0, ce, 1, oen, a, 9'h0);
    e.tag = tag; e.port = p; e.val = v; e.oe = oe;
    q.push_back(e);
    #1 -> sample_ev;
    #0;
    @(negedge clk);
    drive(p, 1, 1, 1, 1, a, 9'h0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 8; i++) begin
      sem_read("R1 reset left", 0, 3'(i), 9'h1FF);
      sem_read("R1 reset right", 1, 3'(i), 9'h1FF);
    end
    sem_write(0, 3, 9'h000);
    sem_read("R2 left holds 3", 0, 3, 9'h000);
    sem_read("R2 right sees 3 taken", 1, 3, 9'h1FF);
    sem_read("R3 no drive with oe high", 0, 3, 9'h000, 1'b0, 1'b1, 1'b1);
    sem_write(1, 3, 9'h000);
    sem_read("R4 right pending", 1, 3, 9'h1FF);
    sem_write(0, 3, 9'h001);
    sem_read("R4 right granted after release", 1, 3, 9'h000);
    sem_read("R7 left released 3", 0, 3, 9'h1FF);
    sem_write(1, 3, 9'h001);
    sem_write(0, 5, 9'h1FE);
    sem_read("R10 upper bits ignored on claim", 0, 5, 9'h000);
    sem_write(0, 5, 9'h0FF);
    sem_read("R10 upper bits ignored on release", 0, 5, 9'h1FF);
    sem_write(0, 6, 9'h000, 1'b0);
    sem_read("R8 illegal write ignored", 0, 6, 9'h1FF);
    sem_read("R8 illegal read not driven", 0, 6, 9'h1FF, 1'b0, 1'b0);
    sem_write(2, 2, 9'h000);
    sem_read("R6 left wins tie", 0, 2, 9'h000);
    sem_read("R6 right loses tie", 1, 2, 9'h1FF);
    sem_write(0, 2, 9'h001);
    sem_read("R6 right pending then granted", 1, 2, 9'h000);
    sem_write(1, 2, 9'h001);
    sem_write(0, 1, 9'h000);
    sem_write(1, 1, 9'h000);
    sem_write(1, 1, 9'h001);
    sem_write(0, 1, 9'h001);
    repeat (3) @(negedge clk);
    sem_read("R7 cancelled request not granted", 1, 1, 9'h1FF);
    sem_read("R7 flag 1 free for left", 0, 1, 9'h1FF);
    sem_write(0, 0, 9'h000);
    sem_write(1, 7, 9'h000);
    sem_read("R9 left holds 0", 0, 0, 9'h000);
    sem_read("R9 right holds 7", 1, 7, 9'h000);
    sem_read("R9 right not on 0", 1, 0, 9'h1FF);
    sem_read("R9 left not on 7", 0, 7, 9'h1FF);
    sem_read("R5 right cannot see 0 held", 1, 0, 9'h1FF);
    repeat (4) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule